// File: doc/BRIEF.md
# Extension Channel Busy Meter

This block turns three free-running 32-bit counters into a single occupancy figure for the secondary (extension) channel of a bonded radio link. The three counters are total elapsed cycles, cycles in which the primary (control) channel was busy, and cycles in which the extension channel was busy. On a request strobe the block takes a snapshot of all three counters. It compares them with the snapshot from the previous request. From the differences it reports extension busy time as a percentage of the time the control channel was clear, in the range 0 to 100.

The block keeps one snapshot per counter. A request made when the stored cycle snapshot is zero counts as a first call. A request made when the stored cycle snapshot is ahead of the live cycle count counts as a counter wrap. In both cases the result is 0. When the control channel had no clear time, the result is 100 at once. Every other request starts a bit-serial restoring divider. The divider works on the extension delta scaled by 100 and runs for a fixed number of cycles. The result appears together with a one-cycle done pulse.

Top module: `ext_busy_meter`

## Requirements
- R1: After reset `busy`, `done` and `busy_pct` are 0 and all three snapshots are zero, so the first accepted request after any reset returns 0.
- R2: An accepted request returns 0 if the stored cycle snapshot is zero, or if it is greater than the current cycle count.
- R3: Control clear time is the cycle delta minus the control-busy delta when the cycle delta is strictly larger, and 0 otherwise. A clear time of 0 returns 100.
- R4: Otherwise the result is floor(extension delta × 100 / control clear). Each delta is the current value minus the snapshot, modulo 2^32. The product is kept wide, so extension deltas up to 2^32-1 do not overflow.
- R5: A computed quotient above 100 is reported as 100, and `busy_pct` never exceeds 100 when `done` is high.
- R6: Every accepted request, including the first-call and wrap cases, replaces all three snapshots with the counter values present at the accepting edge.
- R7: A request is accepted only while `busy` is low. A request raised while `busy` is high neither changes the snapshots nor restarts the calculation.
- R8: `done` is high for exactly one cycle, and `busy_pct` holds its value until the next `done`. Results of 0 from R2 and 100 from R3 appear one cycle after the accepting edge. Divided results appear 40 cycles after it, with the default 32-bit counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_req | input | 1 | Request to snapshot the counters and compute a result |
| cycles_now | input | 32 | Live total-cycle counter |
| ctl_busy_now | input | 32 | Live control-channel busy counter |
| ext_busy_now | input | 32 | Live extension-channel busy counter |
| busy | output | 1 | Division in progress; requests are ignored |
| done | output | 1 | One-cycle pulse: `busy_pct` is fresh |
| busy_pct | output | 7 | Extension busy percentage, 0 to 100 |

## Verification
The checker assumes that a request is only a level that the block samples when it is idle. It does not assume the counter inputs are stable or monotonic. Its "first result is zero" property depends only on reset clearing the snapshots.

The stimulus changes inputs on falling edges and pulses the request for one cycle. The one exception is a deliberate hold during a division, released well before `done`, so that no request goes pending at the cycle the block becomes idle. The counter values wrap the control and extension counters on purpose, to exercise the modular deltas.

// File: rtl/ext_busy_meter.sv
module ext_busy_meter #(
  parameter int CNT_W = 32,
  parameter int PCT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_req,
  input  logic [CNT_W-1:0] cycles_now,
  input  logic [CNT_W-1:0] ctl_busy_now,
  input  logic [CNT_W-1:0] ext_busy_now,
  output logic             busy,
  output logic             done,
  output logic [PCT_W-1:0] busy_pct
);
  localparam int NUM_W  = CNT_W + PCT_W;
  localparam int STEP_W = $clog2(NUM_W + 1);
  localparam logic [PCT_W-1:0] FULL = PCT_W'(100);

  logic [CNT_W-1:0] snap_cyc, snap_ctl, snap_ext;
  logic [CNT_W-1:0] d_cyc, d_ctl, d_ext, ctl_clear;
  logic [NUM_W-1:0] numer;
  logic             accept, no_history;

  logic [NUM_W-1:0]  dvd, quo, quo_nx;
  logic [CNT_W-1:0]  dvs, rem;
  logic [CNT_W:0]    rem_sh, rem_nx;
  logic              fits;
  logic [STEP_W-1:0] step;

  assign accept     = sample_req & ~busy;
  assign d_cyc      = cycles_now - snap_cyc;
  assign d_ctl      = ctl_busy_now - snap_ctl;
  assign d_ext      = ext_busy_now - snap_ext;
  assign no_history = (snap_cyc == '0) || (snap_cyc > cycles_now);
  assign ctl_clear  = (d_cyc > d_ctl) ? (d_cyc - d_ctl) : '0;
  assign numer      = NUM_W'(d_ext) * NUM_W'(100);

  assign rem_sh = {rem, dvd[NUM_W-1]};
  assign fits   = rem_sh >= {1'b0, dvs};
  assign rem_nx = fits ? (rem_sh - {1'b0, dvs}) : rem_sh;
  assign quo_nx = {quo[NUM_W-2:0], fits};

  function automatic logic [PCT_W-1:0] clamp(input logic [NUM_W-1:0] q);
    return (q > NUM_W'(100)) ? FULL : q[PCT_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_cyc <= '0;
      snap_ctl <= '0;
      snap_ext <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      busy_pct <= '0;
      dvd      <= '0;
      dvs      <= '0;
      rem      <= '0;
      quo      <= '0;
      step     <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        snap_cyc <= cycles_now;
        snap_ctl <= ctl_busy_now;
        snap_ext <= ext_busy_now;
        if (no_history) begin
          busy_pct <= '0;
          done     <= 1'b1;
        end else if (ctl_clear == '0) begin
          busy_pct <= FULL;
          done     <= 1'b1;
        end else begin
          busy <= 1'b1;
          dvd  <= numer;
          dvs  <= ctl_clear;
          rem  <= '0;
          quo  <= '0;
          step <= '0;
        end
      end else if (busy) begin
        dvd  <= dvd << 1;
        rem  <= rem_nx[CNT_W-1:0];
        quo  <= quo_nx;
        step <= step + 1'b1;
        if (step == STEP_W'(NUM_W - 1)) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          busy_pct <= clamp(quo_nx);
        end
      end
    end
  end
endmodule

// File: rtl/ext_busy_meter_chk.sv
module ext_busy_meter_chk #(
  parameter int NUM_W = 39,
  parameter int PCT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sample_req,
  input logic             busy,
  input logic             done,
  input logic [PCT_W-1:0] busy_pct
);
  localparam int RUN_W = $clog2(NUM_W + 2);
  logic [RUN_W-1:0] run;
  logic             first_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run        <= '0;
      first_pend <= 1'b1;
    end else begin
      run <= busy ? run + 1'b1 : '0;
      if (done) first_pend <= 1'b0;
    end
  end

  // R1
  first_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && first_pend) |-> busy_pct == '0);
  // R5
  pct_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy_pct <= PCT_W'(100));
  // R7
  req_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_req && !busy) |=> (busy || done));
  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run < RUN_W'(NUM_W));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R8
  pct_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(busy_pct) |-> done);
endmodule

bind ext_busy_meter ext_busy_meter_chk #(.NUM_W(CNT_W + PCT_W), .PCT_W(PCT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_req(sample_req),
  .busy(busy), .done(done), .busy_pct(busy_pct)
);

// File: tb/tb_ext_busy_meter.sv
module tb_ext_busy_meter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_req = 1'b0;
  logic [31:0] cycles_now = '0, ctl_busy_now = '0, ext_busy_now = '0;
  logic        busy, done;
  logic [6:0]  busy_pct;

  int errs = 0, checks = 0, cyc_total = 0;
  localparam int SLOW_LAT = 40;
  localparam int NV = 15;

  // {cycles, ctl_busy, ext_busy, expected pct, divided path}
  localparam logic [104:0] VEC [NV] = '{
    {32'd1000,        32'd100,  32'd50,          8'd0,   1'b0}, // R1 first call
    {32'd2000,        32'd600,  32'd200,         8'd30,  1'b1}, // R4
    {32'd3000,        32'd1100, 32'd300,         8'd20,  1'b1}, // R4
    {32'd3100,        32'd1200, 32'd400,         8'd100, 1'b0}, // R3 equal deltas
    {32'd3200,        32'd1350, 32'd450,         8'd100, 1'b0}, // R3 ctl > cyc
    {32'd3300,        32'd1350, 32'd550,         8'd100, 1'b1}, // R4 exactly 100
    {32'd3400,        32'd1400, 32'd700,         8'd100, 1'b1}, // R5 300 clamped
    {32'd3500,        32'd1400, 32'd701,         8'd1,   1'b1}, // R4
    {32'd3600,        32'd1400, 32'd701,         8'd0,   1'b1}, // R4 zero ext
    {32'd100,         32'd1500, 32'd800,         8'd0,   1'b0}, // R2 wrap
    {32'd400,         32'd1500, 32'd803,         8'd1,   1'b1}, // R6 after wrap
    {32'd700,         32'd1600, 32'd808,         8'd2,   1'b1}, // R4 truncation
    {32'd1000,        32'h10,   32'd808,         8'd100, 1'b0}, // R3 ctl wraps
    {32'hC00003E8,    32'h10,   32'h60000328,    8'd50,  1'b1}, // R4 wide product
    {32'hFFFFFFFF,    32'h10,   32'h60000327,    8'd100, 1'b1}  // R5 max ext delta
  };

  ext_busy_meter dut (
    .clk(clk), .rst_n(rst_n), .sample_req(sample_req),
    .cycles_now(cycles_now), .ctl_busy_now(ctl_busy_now), .ext_busy_now(ext_busy_now),
    .busy(busy), .done(done), .busy_pct(busy_pct)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 100000) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc_total, 100000);
      finish_run();
    end
  end

  task automatic wait_done(output int lat);
    lat = 1;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic do_req(input logic [31:0] c, t, e, output logic [6:0] got, output int lat);
    @(negedge clk);
    cycles_now = c; ctl_busy_now = t; ext_busy_now = e;
    sample_req = 1'b1;
    @(negedge clk);
    sample_req = 1'b0;
    wait_done(lat);
    got = busy_pct;
    @(negedge clk);
    chk("R8 done single cycle", !done, done, 0);
    chk("R8 pct held", busy_pct == got, busy_pct, got);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [6:0] got;
    int lat;
    do_reset();
    chk("R1 busy after reset", busy == 1'b0, busy, 0);
    chk("R1 done after reset", done == 1'b0, done, 0);
    chk("R1 pct after reset", busy_pct == 7'd0, busy_pct, 0);

    for (int i = 0; i < NV; i++) begin
      logic [104:0] v;
      v = VEC[i];
      do_req(v[104:73], v[72:41], v[40:9], got, lat);
      chk($sformatf("R4 vector %0d pct", i), got == v[7:1], got, v[7:1]);
      chk($sformatf("R8 vector %0d latency", i), lat == (v[0] ? SLOW_LAT : 1),
          lat, v[0] ? SLOW_LAT : 1);
    end

    // R1: a fresh reset forgets the snapshots
    do_reset();
    do_req(32'd5000, 32'd10, 32'd10, got, lat);
    chk("R1 first after re-reset", got == 7'd0 && lat == 1, got, 0);
    // R2: current cycle count below snapshot
    do_req(32'd0, 32'd0, 32'd0, got, lat);
    chk("R2 wrap to zero count", got == 7'd0 && lat == 1, got, 0);
    // R2: zero snapshot left by the previous request
    do_req(32'd100, 32'd10, 32'd5, got, lat);
    chk("R2 zero snapshot", got == 7'd0 && lat == 1, got, 0);

    // R7: request held during a division is ignored
    @(negedge clk);
    cycles_now = 32'd300; ctl_busy_now = 32'd60; ext_busy_now = 32'd35;
    sample_req = 1'b1;
    @(negedge clk);
    cycles_now = 32'd900; ext_busy_now = 32'd500;
    repeat (20) @(negedge clk);
    sample_req = 1'b0;
    chk("R7 still busy", busy == 1'b1, busy, 1);
    wait_done(lat);
    chk("R7 result of first request", busy_pct == 7'd20, busy_pct, 20);
    chk("R7 no restart", lat == SLOW_LAT - 20, lat, SLOW_LAT - 20);
    // R6, R7: snapshot is from the accepted request, not the ignored one
    do_req(32'd600, 32'd60, 32'd50, got, lat);
    chk("R7 snapshot untouched", got == 7'd5, got, 5);
    chk("R6 divided latency", lat == SLOW_LAT, lat, SLOW_LAT);

    finish_run();
  end
endmodule